// File: doc/BRIEF.md
# T-State Sequenced Register-Transfer Controller

This block is a hardwired control unit joined to a small register-transfer datapath. A state counter walks through numbered clock states T1 to T6. In each state the controller drives one transfer, or several transfers that do not depend on each other. The datapath holds a program counter, a memory address register, a memory buffer register, an instruction register, four general registers and a carry flag. It reaches an external memory through an address port, a read strobe, a write strobe, a read-data word and a write-data byte.

Every instruction starts with the same fetch, which takes three states:

- T1 copies the program counter into the address register. The program counter is not incremented here, so the address stays steady.
- T2 captures the memory word into the buffer register.
- T3 moves the buffer into the instruction register and increments the program counter in the same cycle.

After the fetch comes a short execute phase whose length depends on the mode code. Immediate load, register move and set-carry each end in T4. Direct load, pointer load and pointer store each end in T6. Undefined codes end after T3. After the last state of any instruction, the counter goes back to T1.

The memory is word addressed. Each 16-bit word holds one instruction: the opcode byte is in the upper half and the operand byte is in the lower half, so a single fetch brings in both. Data transfers use only the low byte of a word. The memory answers a read with data in the same cycle and performs a write on the clock edge while the write strobe is high.

State transitions:

- T1 → T2 always.
- T2 → T3 always.
- T3 → T4 for a known code; T3 → T1 otherwise.
- T4 → T1 for immediate load, register move and set-carry; T4 → T5 for the three memory-operand modes.
- T5 → T6 always.
- T6 → T1 always.

Top module: `tstate_ctrl_unit`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the carry flag, the address, buffer and instruction registers and all general registers. It also sets the state to T1, so the first fetch reads word 0. The state output shows the value n while the block is in state Tn.
- R2: In T1 the address register takes the program counter and the program counter holds its value. In T2 the read strobe is high and the address port shows the un-incremented program counter.
- R3: In T2 the buffer register captures the memory word. In T3 the instruction register takes the buffer and the program counter increases by one in the same cycle.
- R4: Instruction word layout: bits 15:13 hold the mode, bit 12 is spare, bits 11:10 hold field A, bits 9:8 hold field B, and bits 7:0 hold the operand. Mode 0 is the immediate load: in T4 register A takes the operand, and the next state is T1.
- R5: Mode 1 is the register move: in T4 register A takes a copy of register B, and the next state is T1.
- R6: Mode 2 is the direct load: T4 loads the address register from the operand, T5 reads memory with the read strobe high, and T6 writes the low byte of the buffer into register A. T1 follows T6.
- R7: Mode 3 is the pointer load: T4 loads the address register from register B, T5 reads memory, and T6 writes the low byte of the buffer into register A.
- R8: Mode 4 is the pointer store: T4 loads the address register from register A and T5 loads the buffer from register B. In T6 the write strobe is high, with the address register on the address port and the buffer's low byte on the write-data port. The write strobe is never high in any other state.
- R9: Mode 5 sets the carry flag to 1 in T4 and changes no register or memory location. The next state is T1.
- R10: Modes 6 and 7, and any word whose spare bit 12 is set, act as a no-operation. The state returns to T1 after T3, having advanced only the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory word address, driven from the address register |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 16 | Memory word returned in the same cycle as the address |
| mem_wr | output | 1 | Write strobe, the low byte is written at the clock edge |
| mem_wdata | output | 8 | Write data, low byte of the buffer register |
| pc_o | output | 8 | Program counter |
| tstate_o | output | 3 | Current state number, 1 to 6 |
| carry_o | output | 1 | Carry flag |
| regs_o | output | 32 | General registers, register i in bits 8i+7:8i |

## Verification
Several properties are checked on every cycle by the assertions:

- the program counter holds through T1 and advances by one exactly once, after T3;
- the read strobe appears only in T2 and T5, and the write strobe only in T6 of a store;
- the instruction register stays fixed during execute;
- the state falls back to T1 after the last state of every recipe.

Some behaviour can only be shown by the bench's scenarios, which run a program mixing all six modes and both kinds of undefined word, with a model stepping alongside the design. These cover the values that arrive in the general registers. They also cover the byte left in memory by a store and read back through a later pointer load, and the carry and register state across a mid-run reset.

// File: rtl/cs_pkg.sv
package cs_pkg;

    typedef enum logic [2:0] {
        T1 = 3'd1,
        T2 = 3'd2,
        T3 = 3'd3,
        T4 = 3'd4,
        T5 = 3'd5,
        T6 = 3'd6
    } tstate_e;

    localparam logic [2:0] MODE_IMM  = 3'd0;
    localparam logic [2:0] MODE_MOV  = 3'd1;
    localparam logic [2:0] MODE_DIR  = 3'd2;
    localparam logic [2:0] MODE_PLD  = 3'd3;
    localparam logic [2:0] MODE_PST  = 3'd4;
    localparam logic [2:0] MODE_SETC = 3'd5;

    typedef enum logic [2:0] {
        MAR_KEEP,
        MAR_PC,
        MAR_OPND,
        MAR_REG_A,
        MAR_REG_B
    } mar_src_e;

    typedef enum logic [1:0] {
        WB_NONE,
        WB_OPND,
        WB_REG_B,
        WB_BUF
    } wb_src_e;

    typedef struct packed {
        mar_src_e mar_src;
        logic     buf_from_mem;
        logic     buf_from_reg;
        logic     ir_load;
        logic     pc_inc;
        wb_src_e  wb_src;
        logic     carry_set;
        logic     rd_strobe;
        logic     wr_strobe;
    } uop_t;

endpackage

// File: rtl/cs_sequencer.sv
module cs_sequencer
    import cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode,
    input  logic       known,
    output tstate_e    state
);

    tstate_e nxt;

    always_comb begin
        nxt = T1;
        unique case (state)
            T1: nxt = T2;
            T2: nxt = T3;
            T3: nxt = known ? T4 : T1;
            T4: begin
                if (mode == MODE_DIR || mode == MODE_PLD || mode == MODE_PST)
                    nxt = T5;
                else
                    nxt = T1;
            end
            T5: nxt = T6;
            T6: nxt = T1;
            default: nxt = T1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= T1;
        else     state <= nxt;
    end

    AST_LAST_STATE_WRAPS: assert property (@(posedge clk) disable iff (rst)
        state == T6 |=> state == T1);                           // R6
    AST_UNKNOWN_SKIPS: assert property (@(posedge clk) disable iff (rst)
        (state == T3 && !known) |=> state == T1);               // R10

endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
    import cs_pkg::*;
(
    input  tstate_e    state,
    input  logic [2:0] mode,
    output uop_t       uop
);

    always_comb begin
        uop = '{mar_src: MAR_KEEP, wb_src: WB_NONE, default: 1'b0};
        unique case (state)
            T1: uop.mar_src = MAR_PC;
            T2: begin
                uop.buf_from_mem = 1'b1;
                uop.rd_strobe    = 1'b1;
            end
            T3: begin
                uop.ir_load = 1'b1;
                uop.pc_inc  = 1'b1;
            end
            T4: begin
                unique case (mode)
                    MODE_IMM:  uop.wb_src    = WB_OPND;
                    MODE_MOV:  uop.wb_src    = WB_REG_B;
                    MODE_DIR:  uop.mar_src   = MAR_OPND;
                    MODE_PLD:  uop.mar_src   = MAR_REG_B;
                    MODE_PST:  uop.mar_src   = MAR_REG_A;
                    MODE_SETC: uop.carry_set = 1'b1;
                    default:   ;
                endcase
            end
            T5: begin
                if (mode == MODE_PST) begin
                    uop.buf_from_reg = 1'b1;
                end else begin
                    uop.buf_from_mem = 1'b1;
                    uop.rd_strobe    = 1'b1;
                end
            end
            T6: begin
                if (mode == MODE_PST) uop.wr_strobe = 1'b1;
                else                  uop.wb_src    = WB_BUF;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cs_regfile.sv
module cs_regfile #(
    parameter int W     = 8,
    parameter int SEL_W = 2,
    localparam int N    = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [W-1:0]     wdata,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    output logic [W-1:0]     rd_a,
    output logic [W-1:0]     rd_b,
    output logic [N*W-1:0]   flat
);

    logic [W-1:0] q [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                 q[g] <= '0;
            else if (we && wsel == SEL_W'(g))        q[g] <= wdata;
        end
        assign flat[g*W +: W] = q[g];
    end

    assign rd_a = q[sel_a];
    assign rd_b = q[sel_b];

endmodule

// File: rtl/tstate_ctrl_unit.sv
module tstate_ctrl_unit
    import cs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2,
    localparam int IW    = 2 * DATA_W,
    localparam int NREG  = 1 << SEL_W,
    localparam int MODE_HI = IW - 1,
    localparam int SPARE_HI = IW - 4,
    localparam int SPARE_LO = DATA_W + 2 * SEL_W
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic [DATA_W-1:0]      mem_addr,
    output logic                   mem_rd,
    input  logic [IW-1:0]          mem_rdata,
    output logic                   mem_wr,
    output logic [DATA_W-1:0]      mem_wdata,
    output logic [DATA_W-1:0]      pc_o,
    output logic [2:0]             tstate_o,
    output logic                   carry_o,
    output logic [NREG*DATA_W-1:0] regs_o
);

    logic [DATA_W-1:0] pc, mar;
    logic [IW-1:0]     mbr, ir;
    logic              carry;
    tstate_e           state;
    uop_t              uop;

    // During T3 the word is still in the buffer; decode it from there.
    logic [IW-1:0]     opword;
    logic [2:0]        mode;
    logic              known;
    assign opword = (state == T3) ? mbr : ir;
    assign mode   = opword[MODE_HI -: 3];
    assign known  = (opword[SPARE_HI:SPARE_LO] == '0) && (mode <= MODE_SETC);

    logic [SEL_W-1:0]  fld_a, fld_b;
    logic [DATA_W-1:0] opnd, rd_a, rd_b, wb_data;
    logic              wb_en;
    assign fld_a = ir[DATA_W + 2*SEL_W - 1 : DATA_W + SEL_W];
    assign fld_b = ir[DATA_W + SEL_W - 1 : DATA_W];
    assign opnd  = ir[DATA_W-1:0];

    cs_sequencer u_seq (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .known (known),
        .state (state)
    );

    cs_decoder u_dec (
        .state (state),
        .mode  (mode),
        .uop   (uop)
    );

    always_comb begin
        wb_en   = 1'b1;
        wb_data = '0;
        unique case (uop.wb_src)
            WB_OPND:  wb_data = opnd;
            WB_REG_B: wb_data = rd_b;
            WB_BUF:   wb_data = mbr[DATA_W-1:0];
            default:  wb_en   = 1'b0;
        endcase
    end

    cs_regfile #(.W(DATA_W), .SEL_W(SEL_W)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (wb_en),
        .wsel  (fld_a),
        .wdata (wb_data),
        .sel_a (fld_a),
        .sel_b (fld_b),
        .rd_a  (rd_a),
        .rd_b  (rd_b),
        .flat  (regs_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            mar   <= '0;
            mbr   <= '0;
            ir    <= '0;
            carry <= 1'b0;
        end else begin
            unique case (uop.mar_src)
                MAR_PC:    mar <= pc;
                MAR_OPND:  mar <= opnd;
                MAR_REG_A: mar <= rd_a;
                MAR_REG_B: mar <= rd_b;
                default:   ;
            endcase
            if (uop.buf_from_mem)      mbr <= mem_rdata;
            else if (uop.buf_from_reg) mbr <= {{DATA_W{1'b0}}, rd_b};
            if (uop.ir_load)   ir    <= mbr;
            if (uop.pc_inc)    pc    <= pc + 1'b1;
            if (uop.carry_set) carry <= 1'b1;
        end
    end

    assign mem_addr  = mar;
    assign mem_rd    = uop.rd_strobe;
    assign mem_wr    = uop.wr_strobe;
    assign mem_wdata = mbr[DATA_W-1:0];
    assign pc_o      = pc;
    assign tstate_o  = state;
    assign carry_o   = carry;

    AST_PC_HELD_IN_T1: assert property (@(posedge clk) disable iff (rst)
        state == T1 |=> pc == $past(pc));                        // R2
    AST_PC_STEP_AFTER_T3: assert property (@(posedge clk) disable iff (rst)
        state == T3 |=> pc == ($past(pc) + 1'b1));               // R3
    AST_READ_WINDOW: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (state == T2 || state == T5));                // R2
    AST_WRITE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (state == T6 && ir[MODE_HI -: 3] == MODE_PST)); // R8
    AST_IR_STEADY_EXEC: assert property (@(posedge clk) disable iff (rst)
        (state == T4 || state == T5) |=> $stable(ir));           // R3
    AST_CARRY_SET: assert property (@(posedge clk) disable iff (rst)
        (state == T4 && mode == MODE_SETC) |=> carry);           // R9

endmodule

// File: tb/tstate_ctrl_unit_test.sv
module tstate_ctrl_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr, mem_wdata, pc_o;
    logic        mem_rd, mem_wr, carry_o;
    logic [15:0] mem_rdata;
    logic [2:0]  tstate_o;
    logic [31:0] regs_o;

    logic [15:0] mem [256];

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;

    always #10 clk = ~clk;

    tstate_ctrl_unit uut (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .pc_o(pc_o), .tstate_o(tstate_o), .carry_o(carry_o), .regs_o(regs_o)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_wr) mem[mem_addr][7:0] <= mem_wdata;

    // Reference model: behavioural, own memory copy.
    int          m_t;
    logic [7:0]  m_pc, m_mar;
    logic [15:0] m_mbr, m_ir;
    logic [7:0]  m_r [4];
    logic        m_c;
    logic [15:0] m_mem [256];

    function automatic [15:0] ins(input int md, input int a, input int b, input int op);
        ins = {md[2:0], 1'b0, a[1:0], b[1:0], op[7:0]};
    endfunction

    function automatic bit is_known(input logic [15:0] w);
        return (w[12] == 1'b0) && (w[15:13] <= 3'd5);
    endfunction

    function automatic string tag_of(input logic [15:0] w);
        case (w[15:13])
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            3'd5: return "R9";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (rst) begin
            m_t = 1; m_pc = 0; m_mar = 0; m_mbr = 0; m_ir = 0; m_c = 0;
            for (int i = 0; i < 4; i++) m_r[i] = 0;
        end else begin
            int md, a, b;
            md = m_ir[15:13]; a = m_ir[11:10]; b = m_ir[9:8];
            case (m_t)
                1: begin m_mar = m_pc; m_t = 2; end
                2: begin m_mbr = m_mem[m_mar]; m_t = 3; end
                3: begin
                    m_ir = m_mbr; m_pc = m_pc + 1;
                    m_t = is_known(m_ir) ? 4 : 1;
                end
                4: begin
                    m_t = 1;
                    case (md)
                        0: m_r[a] = m_ir[7:0];
                        1: m_r[a] = m_r[b];
                        2: begin m_mar = m_ir[7:0]; m_t = 5; end
                        3: begin m_mar = m_r[b]; m_t = 5; end
                        4: begin m_mar = m_r[a]; m_t = 5; end
                        default: m_c = 1;
                    endcase
                end
                5: begin
                    if (md == 4) m_mbr = {8'h00, m_r[b]};
                    else         m_mbr = m_mem[m_mar];
                    m_t = 6;
                end
                default: begin
                    if (md == 4) m_mem[m_mar][7:0] = m_mbr[7:0];
                    else         m_r[a] = m_mbr[7:0];
                    m_t = 1;
                end
            endcase
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            bit erd, ewr;
            int md;
            md  = m_ir[15:13];
            erd = (m_t == 2) || (m_t == 5 && md != 4);
            ewr = (m_t == 6 && md == 4);
            chk(rst ? "R1" : "R10", "state number", tstate_o, m_t);
            chk("R3", "program counter", pc_o, m_pc);
            chk("R2", "address port", mem_addr, m_mar);
            chk("R2", "read strobe", mem_rd, erd);
            chk("R8", "write strobe", mem_wr, ewr);
            if (ewr) chk("R8", "write data", mem_wdata, m_mbr[7:0]);
            chk("R9", "carry", carry_o, m_c);
            for (int i = 0; i < 4; i++)
                chk(tag_of(m_ir), "register", regs_o[i*8 +: 8], m_r[i]);
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[0] = ins(0, 0, 0, 8'h25);  // r0 <- 25
        mem[1] = ins(0, 1, 0, 8'h40);  // r1 <- 40
        mem[2] = ins(1, 2, 0, 0);      // r2 <- r0
        mem[3] = ins(2, 3, 0, 8'h80);  // r3 <- [80]
        mem[4] = ins(4, 1, 3, 0);      // [r1] <- r3
        mem[5] = ins(3, 0, 1, 0);      // r0 <- [r1]
        mem[6] = ins(6, 2, 2, 8'h11);  // undefined mode
        mem[7] = ins(1, 2, 1, 0) | 16'h1000; // spare bit set
        mem[8] = ins(5, 0, 0, 0);      // set carry
        mem[9] = ins(0, 1, 0, 8'h99);  // r1 <- 99
        mem[8'h80] = 16'h003C;
        mem[8'h40] = 16'hAB77;
        for (int i = 0; i < 256; i++) m_mem[i] = mem[i];

        @(negedge clk); @(negedge clk);
        // R1: reset state
        chk("R1", "reset state", tstate_o, 1);
        chk("R1", "reset pc", pc_o, 0);
        rst = 1'b0;
        repeat (44) @(negedge clk);

        chk("R7", "r0 after pointer load", regs_o[7:0], 8'h3C);
        chk("R4", "r1 immediate", regs_o[15:8], 8'h99);
        chk("R5", "r2 move", regs_o[23:16], 8'h25);
        chk("R6", "r3 direct", regs_o[31:24], 8'h3C);
        chk("R8", "stored low byte", mem[8'h40][7:0], 8'h3C);
        chk("R8", "upper byte untouched", mem[8'h40][15:8], 8'hAB);
        chk("R9", "carry after set", carry_o, 1);
        chk("R10", "pc after two no-ops", pc_o, 10);
        chk("R2", "back at T1", tstate_o, 1);

        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "mid-run reset state", tstate_o, 1);
        chk("R1", "mid-run reset pc", pc_o, 0);
        chk("R1", "mid-run reset carry", carry_o, 0);
        chk("R1", "mid-run reset regs", regs_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2", "first fetch address", pc_o, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        #(20 * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule